// File: doc/BRIEF.md
# Dual-Issue Pairing and Interlock Control

This block is the issue-stage controller of an in-order core that has one scalar pipe and one vector pipe. In every cycle it sees the two oldest decoded instructions, slot 0 and slot 1, in program order. Each instruction arrives with these fields:

- its class;
- two source register indices and one destination register index;
- a latency class;
- a flag-setting bit;
- a repeat count.

From these the block decides whether zero, one or both instructions issue in that cycle. It also tells the decode queue how many entries it may retire.

Some results take two cycles. The block remembers these results for one cycle in a per-register busy scoreboard. When a conditional branch follows a flag setter, the block holds the branch back. An instruction with a non-zero repeat count is expanded into back-to-back issue slots. The decode queue is expected to shift by the consumed count after every clock edge.

Top module: `dual_issue_ctl`

## Requirements
- R1: Class encodings are 00 scalar, 01 vector and 10 branch. Branch counts as a scalar-side instruction. When slot 1 has no conflict with slot 0, these pairs issue together in one cycle: scalar+scalar, vector+scalar, scalar+vector and vector/scalar+branch.
- R2: Two instructions of class vector never issue in the same cycle. The second one waits and issues in a later cycle as slot 0.
- R3: Issue is in order, so slot 1 issues only in a cycle where slot 0 also issues. Slot 0 may write a non-zero register that slot 1 reads through either source or also writes. In that case only slot 0 issues.
- R4: An instruction with latency class 00 (one cycle) creates no stall. A reader of its result may issue in the very next cycle.
- R5: Latency class 01 (multiply), 10 (shift/saturate/clamp) and 11 are two-cycle. In the cycle after such an instruction issues, any instruction in either slot that reads or writes its non-zero destination is held. The hold lasts exactly one cycle.
- R6: Register index 0 never causes a same-cycle dependency or a busy stall.
- R7: A branch never issues in the same cycle as an issuing flag setter. It also never issues in the cycle right after one. The earliest cycle a branch can issue is two cycles after the flag setter.
- R8: A repeat count of n makes the slot 0 instruction issue n+1 times in consecutive unstalled cycles. Slot 1 may pair only with the final repetition. A slot 1 instruction with a non-zero repeat count never pairs.
- R9: The consumed count is the number of instructions whose final repetition issued this cycle. Its value is 0, 1 or 2, and it is 2 whenever slot 1 issues.
- R10: Reset clears the busy scoreboard, the flag hold-off and the repetition counter. With no valid input, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_vld | input | 1 | Slot 0 holds an instruction |
| s0_cls | input | 2 | Slot 0 class |
| s0_ra | input | REG_W | Slot 0 first source register |
| s0_rb | input | REG_W | Slot 0 second source register |
| s0_rd | input | REG_W | Slot 0 destination register |
| s0_lat | input | 2 | Slot 0 latency class |
| s0_setf | input | 1 | Slot 0 sets condition flags |
| s0_rpt | input | RPT_W | Slot 0 extra repetitions |
| s1_vld | input | 1 | Slot 1 holds an instruction |
| s1_cls | input | 2 | Slot 1 class |
| s1_ra | input | REG_W | Slot 1 first source register |
| s1_rb | input | REG_W | Slot 1 second source register |
| s1_rd | input | REG_W | Slot 1 destination register |
| s1_lat | input | 2 | Slot 1 latency class |
| s1_setf | input | 1 | Slot 1 sets condition flags |
| s1_rpt | input | RPT_W | Slot 1 extra repetitions |
| iss0 | output | 1 | Slot 0 issues this cycle |
| iss1 | output | 1 | Slot 1 issues this cycle |
| consumed | output | 2 | Entries the decode queue may retire |

## Verification
Several functions can act in one cycle, and the tests provoke them together on purpose:

- Repeat expansion and pairing meet when a repeated vector instruction is followed by a scalar. The scalar must wait for the final repetition and then go out beside it.
- The busy scoreboard and the pairing check meet when a two-cycle result is read by slot 1. That can happen while slot 0 is free to issue.
- The busy scoreboard and the repeat counter meet when a repeated multiply reads its own destination.

Each scenario drives a small program through a model of the decode queue. The queue advances by the consumed count. The bench compares, for every cycle, the pair of issue bits and the consumed count against a trace worked out by hand from the requirements.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

  typedef enum logic [1:0] {
    CLS_SCALAR = 2'b00,
    CLS_VECTOR = 2'b01,
    CLS_BRANCH = 2'b10,
    CLS_SPARE  = 2'b11
  } iclass_e;

  typedef enum logic [1:0] {
    LAT_ONE   = 2'b00,
    LAT_MUL   = 2'b01,
    LAT_SHSAT = 2'b10,
    LAT_SPARE = 2'b11
  } latcls_e;

  function automatic logic is_vector(input logic [1:0] cls);
    return cls == CLS_VECTOR;
  endfunction

  function automatic logic is_branch(input logic [1:0] cls);
    return cls == CLS_BRANCH;
  endfunction

  // any latency class other than the plain one keeps the result for two cycles
  function automatic logic is_two_cycle(input logic [1:0] lat);
    return lat != LAT_ONE;
  endfunction

  // only one vector pipe exists
  function automatic logic class_pair_ok(input logic [1:0] c0, input logic [1:0] c1);
    return !(is_vector(c0) && is_vector(c1));
  endfunction

  function automatic logic [1:0] count_done(input logic a, input logic b);
    return {1'b0, a} + {1'b0, b};
  endfunction

endpackage

// File: rtl/di_scoreboard.sv
module di_scoreboard #(
  parameter int NREG = 32,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set0_en,
  input  logic [REG_W-1:0] set0_idx,
  input  logic             set1_en,
  input  logic [REG_W-1:0] set1_idx,
  output logic [NREG-1:0]  busy
);

  logic [NREG-1:0] busy_d;

  // register 0 is never tracked
  assign busy_d[0] = 1'b0;

  generate
    for (genvar r = 1; r < NREG; r++) begin : g_reg
      // a two-cycle result is pending only in the cycle after its issue
      assign busy_d[r] = (set0_en && (set0_idx == REG_W'(r))) ||
                         (set1_en && (set1_idx == REG_W'(r)));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= '0;
    else        busy <= busy_d;
  end

endmodule

// File: rtl/di_hazard.sv
module di_hazard #(
  parameter int NREG = 32,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  busy,
  input  logic [REG_W-1:0] ra,
  input  logic [REG_W-1:0] rb,
  input  logic [REG_W-1:0] rd,
  output logic             hit
);

  logic hit_a, hit_b, hit_d;

  assign hit_a = (ra != '0) && busy[ra];
  assign hit_b = (rb != '0) && busy[rb];
  assign hit_d = (rd != '0) && busy[rd];
  assign hit   = hit_a || hit_b || hit_d;

endmodule

// File: rtl/di_repeat.sv
module di_repeat #(
  parameter int RPT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [RPT_W-1:0] rpt,
  output logic             last
);

  logic [RPT_W-1:0] done_q;

  assign last = (done_q == rpt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   done_q <= '0;
    else if (adv) done_q <= last ? '0 : done_q + 1'b1;
  end

endmodule

// File: rtl/dual_issue_ctl.sv
module dual_issue_ctl
  import dual_issue_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int RPT_W = 2,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s0_vld,
  input  logic [1:0]       s0_cls,
  input  logic [REG_W-1:0] s0_ra,
  input  logic [REG_W-1:0] s0_rb,
  input  logic [REG_W-1:0] s0_rd,
  input  logic [1:0]       s0_lat,
  input  logic             s0_setf,
  input  logic [RPT_W-1:0] s0_rpt,
  input  logic             s1_vld,
  input  logic [1:0]       s1_cls,
  input  logic [REG_W-1:0] s1_ra,
  input  logic [REG_W-1:0] s1_rb,
  input  logic [REG_W-1:0] s1_rd,
  input  logic [1:0]       s1_lat,
  input  logic             s1_setf,
  input  logic [RPT_W-1:0] s1_rpt,
  output logic             iss0,
  output logic             iss1,
  output logic [1:0]       consumed
);

  localparam int NSLOT = 2;

  logic [NREG-1:0]  busy_q;
  logic             flag_pend_q;
  logic [NSLOT-1:0] haz;
  logic [REG_W-1:0] ra_v [NSLOT];
  logic [REG_W-1:0] rb_v [NSLOT];
  logic [REG_W-1:0] rd_v [NSLOT];
  logic             last0;

  assign ra_v[0] = s0_ra;  assign ra_v[1] = s1_ra;
  assign rb_v[0] = s0_rb;  assign rb_v[1] = s1_rb;
  assign rd_v[0] = s0_rd;  assign rd_v[1] = s1_rd;

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      di_hazard #(.NREG(NREG)) u_haz (
        .busy (busy_q),
        .ra   (ra_v[g]),
        .rb   (rb_v[g]),
        .rd   (rd_v[g]),
        .hit  (haz[g])
      );
    end
  endgenerate

  // named events for the checker
  logic stall_busy0, stall_flag0, go0;
  logic pair_vv, pair_dep, pair_flag, pair_rpt, pair_busy, go1;
  logic done0;

  assign stall_busy0 = s0_vld && haz[0];
  assign stall_flag0 = s0_vld && is_branch(s0_cls) && flag_pend_q;
  assign go0         = s0_vld && !haz[0] && !stall_flag0;

  assign pair_vv   = !class_pair_ok(s0_cls, s1_cls);
  assign pair_dep  = (s0_rd != '0) &&
                     ((s1_ra == s0_rd) || (s1_rb == s0_rd) || (s1_rd == s0_rd));
  assign pair_flag = is_branch(s1_cls) && (s0_setf || flag_pend_q);
  assign pair_rpt  = (s1_rpt != '0) || !last0;
  assign pair_busy = haz[1];

  assign go1 = go0 && s1_vld && !pair_vv && !pair_dep && !pair_flag &&
               !pair_rpt && !pair_busy;

  assign done0    = go0 && last0;
  assign iss0     = go0;
  assign iss1     = go1;
  assign consumed = count_done(done0, go1);

  di_repeat #(.RPT_W(RPT_W)) u_rpt (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (go0),
    .rpt   (s0_rpt),
    .last  (last0)
  );

  di_scoreboard #(.NREG(NREG)) u_sb (
    .clk      (clk),
    .rst_n    (rst_n),
    .set0_en  (go0 && is_two_cycle(s0_lat)),
    .set0_idx (s0_rd),
    .set1_en  (go1 && is_two_cycle(s1_lat)),
    .set1_idx (s1_rd),
    .busy     (busy_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_pend_q <= 1'b0;
    else        flag_pend_q <= (go0 && s0_setf) || (go1 && s1_setf);
  end

endmodule

// File: rtl/di_ctl_chk.sv
module di_ctl_chk #(
  parameter int NREG = 32,
  localparam int REG_W = $clog2(NREG)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s0_vld,
  input logic [1:0]       s0_cls,
  input logic [REG_W-1:0] s0_ra,
  input logic [REG_W-1:0] s0_rb,
  input logic [REG_W-1:0] s0_rd,
  input logic [1:0]       s0_lat,
  input logic             s0_setf,
  input logic [1:0]       s1_cls,
  input logic [REG_W-1:0] s1_ra,
  input logic [REG_W-1:0] s1_rb,
  input logic [REG_W-1:0] s1_rd,
  input logic             s1_setf,
  input logic             iss0,
  input logic             iss1,
  input logic [1:0]       consumed,
  input logic             stall_busy0
);

  // R2
  vec_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss1 |-> !(s0_cls == 2'b01 && s1_cls == 2'b01));

  // R3
  in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss1 |-> iss0);

  // R3
  same_cycle_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss1 && s0_rd != '0) |-> (s1_ra != s0_rd && s1_rb != s0_rd && s1_rd != s0_rd));

  // R5
  two_cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(iss0 && s0_lat != 2'b00 && s0_rd != '0) &&
     (s0_ra == $past(s0_rd) || s0_rb == $past(s0_rd) || s0_rd == $past(s0_rd)))
    |-> !iss0);

  // R5
  busy_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_busy0 |=> !stall_busy0);

  // R7
  flag_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past((iss0 && s0_setf) || (iss1 && s1_setf)) && s0_cls == 2'b10)
    |-> !iss0);

  // R7
  flag_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss1 && s1_cls == 2'b10) |-> !s0_setf);

  // R9
  consume_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss1 |-> consumed == 2'd2);

  // R9
  consume_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss0 |-> consumed == 2'd0);

  // R9
  valid_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss0 |-> s0_vld);

endmodule

bind dual_issue_ctl di_ctl_chk #(.NREG(NREG)) u_chk (.*);

// File: tb/tb_dual_issue_ctl.sv
`timescale 1ns/100ps
module tb_dual_issue_ctl;

  localparam int NREG  = 32;
  localparam int RPT_W = 2;
  localparam int REG_W = $clog2(NREG);

  typedef struct packed {
    logic [1:0]       cls;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] ra;
    logic [REG_W-1:0] rb;
    logic [1:0]       lat;
    logic             setf;
    logic [RPT_W-1:0] rpt;
  } ins_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s0_vld, s0_setf, s1_vld, s1_setf;
  logic [1:0] s0_cls, s0_lat, s1_cls, s1_lat;
  logic [REG_W-1:0] s0_ra, s0_rb, s0_rd, s1_ra, s1_rb, s1_rd;
  logic [RPT_W-1:0] s0_rpt, s1_rpt;
  logic iss0, iss1;
  logic [1:0] consumed;

  always #2.5 clk = ~clk;

  dual_issue_ctl #(.NREG(NREG), .RPT_W(RPT_W)) dut (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  ins_t prog [16];
  int   plen;
  int   head;

  function automatic ins_t mk(logic [1:0] cls, int rd, int ra, int rb,
                              logic [1:0] lat, logic setf, int rpt);
    ins_t t;
    t.cls = cls; t.rd = REG_W'(rd); t.ra = REG_W'(ra); t.rb = REG_W'(rb);
    t.lat = lat; t.setf = setf; t.rpt = RPT_W'(rpt);
    return t;
  endfunction

  function automatic ins_t sc(int rd, int ra, int rb);
    return mk(2'b00, rd, ra, rb, 2'b00, 1'b0, 0);
  endfunction

  task automatic clear_prog();
    plen = 0;
  endtask

  task automatic push(ins_t t);
    prog[plen] = t;
    plen++;
  endtask

  task automatic drive_slots();
    ins_t a, b;
    a = (head < plen)     ? prog[head]     : '0;
    b = (head + 1 < plen) ? prog[head + 1] : '0;
    s0_vld = head < plen;
    s0_cls = a.cls; s0_ra = a.ra; s0_rb = a.rb; s0_rd = a.rd;
    s0_lat = a.lat; s0_setf = a.setf; s0_rpt = a.rpt;
    s1_vld = head + 1 < plen;
    s1_cls = b.cls; s1_ra = b.ra; s1_rb = b.rb; s1_rd = b.rd;
    s1_lat = b.lat; s1_setf = b.setf; s1_rpt = b.rpt;
  endtask

  task automatic check4(string req, string what, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got {iss1,iss0,consumed}=%h expected %h", req, what, got, exp);
    end
  endtask

  // trace nibble per cycle {iss1, iss0, consumed[1:0]}, first cycle leftmost
  task automatic run_prog(string req, string name, int ncyc, logic [63:0] exp);
    head = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      drive_slots();
      #1;
      check4(req, $sformatf("%s cycle %0d", name, i), {iss1, iss0, consumed},
             exp[4*(ncyc-1-i) +: 4]);
      head += int'(consumed);
    end
    @(negedge clk);
    head = plen;
    drive_slots();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    head = plen;
    drive_slots();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    clear_prog();
    do_reset();
    #1;
    check4("R10", "idle after reset", {iss1, iss0, consumed}, 4'h0);
  endtask

  task automatic t_pairs();
    clear_prog();
    push(sc(1, 2, 3)); push(sc(4, 5, 6)); push(sc(7, 8, 9)); push(sc(10, 11, 12));
    run_prog("R1", "scalar pairs", 3, 64'hEE0);
    clear_prog();
    push(mk(2'b01, 1, 2, 3, 2'b00, 1'b0, 0)); push(sc(4, 5, 6));
    push(mk(2'b10, 0, 0, 0, 2'b00, 1'b0, 0)); push(sc(7, 8, 9));
    run_prog("R1", "vector+scalar, branch+scalar", 3, 64'hEE0);
  endtask

  task automatic t_vec_vec();
    clear_prog();
    push(mk(2'b01, 1, 2, 3, 2'b00, 1'b0, 0));
    push(mk(2'b01, 4, 5, 6, 2'b00, 1'b0, 0));
    push(mk(2'b01, 7, 8, 9, 2'b00, 1'b0, 0));
    run_prog("R2", "three vectors", 4, 64'h5550);
  endtask

  task automatic t_dep();
    clear_prog();
    push(sc(1, 2, 3)); push(sc(4, 1, 5)); push(sc(6, 4, 0));
    run_prog("R3", "read-after-write chain", 4, 64'h5550);
    clear_prog();
    push(sc(1, 2, 3)); push(sc(1, 7, 8));
    run_prog("R3", "write-after-write", 3, 64'h550);
  endtask

  task automatic t_one_cycle();
    clear_prog();
    push(mk(2'b01, 1, 2, 3, 2'b00, 1'b0, 0)); push(sc(9, 8, 8));
    push(sc(4, 1, 0)); push(sc(5, 6, 7));
    run_prog("R4", "plain latency reader next cycle", 3, 64'hEE0);
  endtask

  task automatic t_two_cycle();
    clear_prog();
    push(mk(2'b01, 1, 2, 3, 2'b01, 1'b0, 0)); push(sc(4, 1, 0)); push(sc(5, 6, 7));
    run_prog("R5", "multiply then reader", 4, 64'h50E0);
    clear_prog();
    push(sc(9, 8, 8)); push(mk(2'b01, 1, 2, 3, 2'b10, 1'b0, 0)); push(sc(4, 0, 1));
    run_prog("R5", "saturate in slot 1 then reader", 4, 64'hE050);
    clear_prog();
    push(mk(2'b01, 1, 2, 3, 2'b10, 1'b0, 0)); push(sc(9, 8, 8));
    push(sc(10, 11, 12)); push(sc(4, 1, 0));
    run_prog("R5", "busy reader held in slot 1", 4, 64'hE550);
  endtask

  task automatic t_reg_zero();
    clear_prog();
    push(mk(2'b01, 0, 2, 3, 2'b01, 1'b0, 0)); push(sc(5, 0, 0)); push(sc(6, 0, 0));
    run_prog("R6", "register 0 never blocks", 3, 64'hE50);
  endtask

  task automatic t_flag();
    clear_prog();
    push(mk(2'b00, 1, 2, 3, 2'b00, 1'b1, 0));
    push(mk(2'b10, 0, 0, 0, 2'b00, 1'b0, 0)); push(sc(2, 3, 4));
    run_prog("R7", "branch right after flag setter", 4, 64'h50E0);
    clear_prog();
    push(mk(2'b00, 1, 2, 3, 2'b00, 1'b1, 0)); push(sc(4, 5, 6)); push(sc(7, 8, 9));
    push(mk(2'b10, 0, 0, 0, 2'b00, 1'b0, 0));
    run_prog("R7", "branch in slot 1 next cycle", 4, 64'hE550);
  endtask

  task automatic t_repeat();
    clear_prog();
    push(mk(2'b01, 1, 2, 3, 2'b00, 1'b0, 1)); push(sc(4, 5, 6));
    run_prog("R8", "2x vector pairs on last", 3, 64'h4E0);
    clear_prog();
    push(mk(2'b01, 1, 2, 3, 2'b00, 1'b0, 3));
    run_prog("R8", "4x vector", 5, 64'h44450);
    clear_prog();
    push(sc(1, 2, 3)); push(mk(2'b01, 4, 5, 6, 2'b00, 1'b0, 1));
    run_prog("R8", "repeated slot 1 waits", 4, 64'h5450);
    clear_prog();
    push(mk(2'b01, 1, 1, 2, 2'b01, 1'b0, 1));
    run_prog("R8", "2x multiply on own result", 4, 64'h4050);
  endtask

  task automatic t_mid_reset();
    clear_prog();
    push(mk(2'b01, 1, 2, 3, 2'b01, 1'b1, 1));
    head = 0;
    @(negedge clk);
    drive_slots();
    #1;
    check4("R10", "first repetition before reset", {iss1, iss0, consumed}, 4'h4);
    do_reset();
    clear_prog();
    push(mk(2'b10, 0, 1, 0, 2'b00, 1'b0, 0)); push(mk(2'b01, 5, 1, 6, 2'b00, 1'b0, 1));
    run_prog("R10", "state cleared by reset", 4, 64'h5450);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    clear_prog();
    head = 0;
    drive_slots();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_pairs();
    t_vec_vec();
    t_dep();
    t_one_cycle();
    t_two_cycle();
    t_reg_zero();
    t_flag();
    t_repeat();
    t_mid_reset();
    finished = 1;
    summary();
  end

endmodule